// File: doc/BRIEF.md
# Branch Next-Address Unit

This unit sits beside the decoder of an 8-bit microcontroller core that has a 16-bit program counter. When an opcode that transfers control has been decoded and its operand bytes fetched, the core presents the opcode, the operand bytes and the program counter. That counter has already been advanced past the whole instruction. The core also presents the operands the branch depends on: the accumulator, the data pointer, the carry flag, the value of the addressed bit, the two compare operands and the value to be decremented.

One clock later the unit returns the program counter for the next instruction and a taken flag. It also returns the side effects the instruction asks the core to commit: a new carry value with its write strobe, a strobe that clears the tested bit, and a decremented byte with its write strobe. It covers page-absolute, long, short-relative, indirect, flag-conditional, bit-conditional, compare and decrement branches. Stack pushes, instruction fetch and memory access stay with the core.

Top module: `brnext_unit`

## Requirements
- R1: Opcodes of the form xxx0_0001 jump to a target whose bits 15..11 come from `pc_seq`, bits 10..8 from opcode bits 7..5 and bits 7..0 from `opnd1`; `taken` is 1.
- R2: Opcode 0x02 jumps to {`opnd1`,`opnd2`}, where `opnd1` is the high byte; `taken` is 1.
- R3: Opcode 0x80 jumps to `pc_seq` plus `opnd1` taken as a signed byte, modulo 2^16; `taken` is 1.
- R4: Opcode 0x40 branches by `opnd1` (relative, signed) when `cy_in` is 1, and opcode 0x50 does so when `cy_in` is 0.
- R5: Opcode 0x60 branches by `opnd1` when all bits of `acc` are 0, and opcode 0x70 does so when any bit of `acc` is 1.
- R6: Opcode 0x73 jumps to `dptr` plus zero-extended `acc`, modulo 2^16.
- R7: Opcodes 0xB4 to 0xBF raise `cy_we` with `cy_new` = (`cmp_lhs` < `cmp_rhs`, unsigned) and branch by `opnd2` only when the two compare operands differ.
- R8: Opcode 0xD5 (offset in `opnd2`) and opcodes 0xD8 to 0xDF (offset in `opnd1`) raise `dec_we` with `dec_val` = `dec_src` − 1 modulo 256, and branch only when that result is nonzero.
- R9: Opcode 0x20 branches by `opnd2` when `bit_val` is 1 and opcode 0x30 when it is 0. Opcode 0x10 branches by `opnd2` when `bit_val` is 1 and raises `bit_clr` in exactly that case.
- R10: A conditional branch whose condition is false returns `next_pc` equal to `pc_seq` with `taken` at 0.
- R11: Any other opcode (for example 0x03, 0x12 or 0xA5) returns `pc_seq` with `taken`, `cy_we`, `bit_clr` and `dec_we` all at 0.
- R12: Results appear one cycle after `in_valid`. A cycle without `in_valid` gives `out_valid`, `taken` and all strobes at 0 and leaves `next_pc` unchanged. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Opcode and operands are presented this cycle |
| op | input | 8 | Decoded opcode byte |
| opnd1 | input | 8 | First operand byte |
| opnd2 | input | 8 | Second operand byte |
| pc_seq | input | 16 | Program counter past the instruction |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| cy_in | input | 1 | Current carry flag |
| bit_val | input | 1 | Value of the addressed bit |
| cmp_lhs | input | 8 | First compare operand |
| cmp_rhs | input | 8 | Second compare operand |
| dec_src | input | 8 | Value to decrement |
| out_valid | output | 1 | Result registers hold a fresh result |
| next_pc | output | 16 | Program counter for the next instruction |
| taken | output | 1 | Control left the sequential path |
| cy_we | output | 1 | Write `cy_new` to the carry flag |
| cy_new | output | 1 | New carry value |
| bit_clr | output | 1 | Clear the tested bit |
| dec_we | output | 1 | Write `dec_val` back |
| dec_val | output | 8 | Decremented value |

## Verification
The bench builds the unit with its default widths: a 16-bit counter, 8-bit data and an 11-bit page offset. With these widths a signed offset can carry the target across 0x0000 and 0xFFFF, a page jump near the top of memory can keep the upper five counter bits, and a data pointer near 0xFFFF plus the accumulator wraps to a low address. The 8-bit compare operands let the bench set 0x00 against 0xFF, which shows the less-than test is unsigned, and the 8-bit decrement shows the wrap from 0x00 to 0xFF.

// File: rtl/brnext_pkg.sv
package brnext_pkg;

  typedef enum logic [3:0] {
    BK_NONE,
    BK_PAGE,
    BK_LONG,
    BK_SHORT,
    BK_CY,
    BK_NCY,
    BK_ZERO,
    BK_NZERO,
    BK_BITSET,
    BK_BITCLR,
    BK_BITTAKE,
    BK_INDIR,
    BK_CMP,
    BK_DEC
  } br_kind_e;

  typedef struct packed {
    br_kind_e kind;
    logic     off_second;
  } br_dec_t;

  localparam logic [7:0] OPC_LONG    = 8'h02;
  localparam logic [7:0] OPC_BITTAKE = 8'h10;
  localparam logic [7:0] OPC_BITSET  = 8'h20;
  localparam logic [7:0] OPC_BITCLR  = 8'h30;
  localparam logic [7:0] OPC_CY      = 8'h40;
  localparam logic [7:0] OPC_NCY     = 8'h50;
  localparam logic [7:0] OPC_ZERO    = 8'h60;
  localparam logic [7:0] OPC_NZERO   = 8'h70;
  localparam logic [7:0] OPC_INDIR   = 8'h73;
  localparam logic [7:0] OPC_SHORT   = 8'h80;
  localparam logic [7:0] OPC_CMP_IMM = 8'hB4;
  localparam logic [7:0] OPC_CMP_DIR = 8'hB5;
  localparam logic [7:0] OPC_DEC_DIR = 8'hD5;

endpackage

// File: rtl/brnext_decode.sv
module brnext_decode
  import brnext_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] op,
  output br_dec_t       dec
);

  always_comb begin
    dec.kind       = BK_NONE;
    dec.off_second = 1'b0;
    casez (op)
      8'b???0_0001: dec.kind = BK_PAGE;
      OPC_LONG:     dec.kind = BK_LONG;
      OPC_SHORT:    dec.kind = BK_SHORT;
      OPC_CY:       dec.kind = BK_CY;
      OPC_NCY:      dec.kind = BK_NCY;
      OPC_ZERO:     dec.kind = BK_ZERO;
      OPC_NZERO:    dec.kind = BK_NZERO;
      OPC_INDIR:    dec.kind = BK_INDIR;
      OPC_BITSET: begin
        dec.kind       = BK_BITSET;
        dec.off_second = 1'b1;
      end
      OPC_BITCLR: begin
        dec.kind       = BK_BITCLR;
        dec.off_second = 1'b1;
      end
      OPC_BITTAKE: begin
        dec.kind       = BK_BITTAKE;
        dec.off_second = 1'b1;
      end
      OPC_CMP_IMM, OPC_CMP_DIR, 8'b1011_011?, 8'b1011_1???: begin
        dec.kind       = BK_CMP;
        dec.off_second = 1'b1;
      end
      OPC_DEC_DIR: begin
        dec.kind       = BK_DEC;
        dec.off_second = 1'b1;
      end
      8'b1101_1???: dec.kind = BK_DEC;
      default: dec.kind = BK_NONE;
    endcase
  end

endmodule

// File: rtl/brnext_target.sv
module brnext_target
  import brnext_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int DW   = 8,
  parameter int PG_W = 11
) (
  input  br_kind_e        kind,
  input  logic            off_second,
  input  logic [DW-1:0]   op,
  input  logic [DW-1:0]   opnd1,
  input  logic [DW-1:0]   opnd2,
  input  logic [PC_W-1:0] pc_seq,
  input  logic [DW-1:0]   acc,
  input  logic [PC_W-1:0] dptr,
  output logic [PC_W-1:0] tgt
);

  localparam int EXT_W = PC_W - DW;
  localparam int HI_W  = PG_W - DW;

  logic [DW-1:0]   rel_byte;
  logic [PC_W-1:0] rel_tgt;
  logic [PC_W-1:0] page_tgt;
  logic [PC_W-1:0] long_tgt;
  logic [PC_W-1:0] indir_tgt;

  assign rel_byte  = off_second ? opnd2 : opnd1;
  assign rel_tgt   = pc_seq + {{EXT_W{rel_byte[DW-1]}}, rel_byte};
  assign page_tgt  = {pc_seq[PC_W-1:PG_W], op[DW-1 -: HI_W], opnd1};
  assign indir_tgt = dptr + {{EXT_W{1'b0}}, acc};

  generate
    if (PC_W >= 2 * DW) begin : g_long_wide
      assign long_tgt = {{(PC_W - 2 * DW){1'b0}}, opnd1, opnd2};
    end else begin : g_long_narrow
      logic [2*DW-1:0] long_full;
      assign long_full = {opnd1, opnd2};
      assign long_tgt  = long_full[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (kind)
      BK_PAGE:  tgt = page_tgt;
      BK_LONG:  tgt = long_tgt;
      BK_INDIR: tgt = indir_tgt;
      default:  tgt = rel_tgt;
    endcase
  end

endmodule

// File: rtl/brnext_cond.sv
module brnext_cond
  import brnext_pkg::*;
#(
  parameter int DW = 8
) (
  input  br_kind_e      kind,
  input  logic          cy_in,
  input  logic [DW-1:0] acc,
  input  logic          bit_val,
  input  logic [DW-1:0] cmp_lhs,
  input  logic [DW-1:0] cmp_rhs,
  input  logic [DW-1:0] dec_src,
  output logic          take,
  output logic          cy_we,
  output logic          cy_new,
  output logic          bit_clr,
  output logic          dec_we,
  output logic [DW-1:0] dec_val
);

  logic acc_zero;

  assign acc_zero = (acc == '0);
  assign dec_val  = dec_src - {{(DW-1){1'b0}}, 1'b1};

  always_comb begin
    take    = 1'b0;
    cy_we   = 1'b0;
    cy_new  = 1'b0;
    bit_clr = 1'b0;
    dec_we  = 1'b0;
    unique case (kind)
      BK_PAGE, BK_LONG, BK_SHORT, BK_INDIR: take = 1'b1;
      BK_CY:      take = cy_in;
      BK_NCY:     take = ~cy_in;
      BK_ZERO:    take = acc_zero;
      BK_NZERO:   take = ~acc_zero;
      BK_BITSET:  take = bit_val;
      BK_BITCLR:  take = ~bit_val;
      BK_BITTAKE: begin
        take    = bit_val;
        bit_clr = bit_val;
      end
      BK_CMP: begin
        take   = (cmp_lhs != cmp_rhs);
        cy_we  = 1'b1;
        cy_new = (cmp_lhs < cmp_rhs);
      end
      BK_DEC: begin
        take   = (dec_val != '0);
        dec_we = 1'b1;
      end
      default: take = 1'b0;
    endcase
  end

endmodule

// File: rtl/brnext_unit.sv
module brnext_unit
  import brnext_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int DW   = 8,
  parameter int PG_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [DW-1:0]   op,
  input  logic [DW-1:0]   opnd1,
  input  logic [DW-1:0]   opnd2,
  input  logic [PC_W-1:0] pc_seq,
  input  logic [DW-1:0]   acc,
  input  logic [PC_W-1:0] dptr,
  input  logic            cy_in,
  input  logic            bit_val,
  input  logic [DW-1:0]   cmp_lhs,
  input  logic [DW-1:0]   cmp_rhs,
  input  logic [DW-1:0]   dec_src,
  output logic            out_valid,
  output logic [PC_W-1:0] next_pc,
  output logic            taken,
  output logic            cy_we,
  output logic            cy_new,
  output logic            bit_clr,
  output logic            dec_we,
  output logic [DW-1:0]   dec_val
);

  // reset: asserted at once, released through two flops
  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  br_dec_t         dec;
  logic [PC_W-1:0] tgt;
  logic            c_take;
  logic            c_cy_we;
  logic            c_cy_new;
  logic            c_bit_clr;
  logic            c_dec_we;
  logic [DW-1:0]   c_dec_val;

  brnext_decode #(.DW(DW)) u_decode (
    .op  (op),
    .dec (dec)
  );

  brnext_target #(.PC_W(PC_W), .DW(DW), .PG_W(PG_W)) u_target (
    .kind       (dec.kind),
    .off_second (dec.off_second),
    .op         (op),
    .opnd1      (opnd1),
    .opnd2      (opnd2),
    .pc_seq     (pc_seq),
    .acc        (acc),
    .dptr       (dptr),
    .tgt        (tgt)
  );

  brnext_cond #(.DW(DW)) u_cond (
    .kind    (dec.kind),
    .cy_in   (cy_in),
    .acc     (acc),
    .bit_val (bit_val),
    .cmp_lhs (cmp_lhs),
    .cmp_rhs (cmp_rhs),
    .dec_src (dec_src),
    .take    (c_take),
    .cy_we   (c_cy_we),
    .cy_new  (c_cy_new),
    .bit_clr (c_bit_clr),
    .dec_we  (c_dec_we),
    .dec_val (c_dec_val)
  );

  // next-state
  logic [PC_W-1:0] pc_d;
  logic            valid_d, taken_d, cy_we_d, bit_clr_d, dec_we_d;
  logic            load_en;

  assign load_en = in_valid;

  always_comb begin
    valid_d   = in_valid;
    taken_d   = in_valid & c_take;
    cy_we_d   = in_valid & c_cy_we;
    bit_clr_d = in_valid & c_bit_clr;
    dec_we_d  = in_valid & c_dec_we;
    pc_d      = c_take ? tgt : pc_seq;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      cy_we     <= 1'b0;
      bit_clr   <= 1'b0;
      dec_we    <= 1'b0;
    end else begin
      out_valid <= valid_d;
      taken     <= taken_d;
      cy_we     <= cy_we_d;
      bit_clr   <= bit_clr_d;
      dec_we    <= dec_we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      next_pc <= '0;
      cy_new  <= 1'b0;
      dec_val <= '0;
    end else if (load_en) begin
      next_pc <= pc_d;
      cy_new  <= c_cy_new;
      dec_val <= c_dec_val;
    end
  end

  // checks on the registered results
  a_r10_fallthrough: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (out_valid && !taken) |-> (next_pc == $past(pc_seq)));

  a_r12_strobe_needs_valid: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (taken || cy_we || bit_clr || dec_we) |-> out_valid);

  a_r9_clear_only_on_jump: assert property (@(posedge clk) disable iff (!rst_sync_q)
    bit_clr |-> taken);

  a_r8_dec_value: assert property (@(posedge clk) disable iff (!rst_sync_q)
    dec_we |-> (dec_val == DW'($past(dec_src) - 1'b1)));

  a_r12_hold_idle: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !$past(in_valid) |-> $stable(next_pc));

endmodule

// File: tb/brnext_unit_test.sv
`timescale 1ns/1ps
module brnext_unit_test;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  op, opnd1, opnd2, acc, cmp_lhs, cmp_rhs, dec_src;
  logic [15:0] pc_seq, dptr;
  logic        cy_in, bit_val;
  logic        out_valid, taken, cy_we, cy_new, bit_clr, dec_we;
  logic [15:0] next_pc;
  logic [7:0]  dec_val;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  brnext_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .opnd1(opnd1),
    .opnd2(opnd2), .pc_seq(pc_seq), .acc(acc), .dptr(dptr), .cy_in(cy_in),
    .bit_val(bit_val), .cmp_lhs(cmp_lhs), .cmp_rhs(cmp_rhs), .dec_src(dec_src),
    .out_valid(out_valid), .next_pc(next_pc), .taken(taken), .cy_we(cy_we),
    .cy_new(cy_new), .bit_clr(bit_clr), .dec_we(dec_we), .dec_val(dec_val)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [7:0]  req;
    logic [7:0]  op;
    logic [7:0]  o1;
    logic [7:0]  o2;
    logic [15:0] pc;
    logic [7:0]  acc;
    logic [15:0] dp;
    logic        cy;
    logic        bt;
    logic [7:0]  lhs;
    logic [7:0]  rhs;
    logic [7:0]  dsrc;
    logic [15:0] e_pc;
    logic        e_tk;
    logic        e_cwe;
    logic        e_cy;
    logic        e_bclr;
    logic        e_dwe;
    logic [7:0]  e_dval;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t TBL [NV] = '{
    // R1 page-absolute
    '{8'd1, 8'hE1, 8'h34, 8'h00, 16'h5ABC, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 16'h5F34, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{8'd1, 8'h21, 8'hFF, 8'h00, 16'hF802, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 16'hF9FF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    // R2 long
    '{8'd2, 8'h02, 8'h12, 8'h34, 16'h8000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 16'h1234, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    // R3 short relative, wrap and most negative offset
    '{8'd3, 8'h80, 8'h10, 8'h00, 16'h1000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 16'h1010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{8'd3, 8'h80, 8'hFE, 8'h00, 16'h0001, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{8'd3, 8'h80, 8'h80, 8'h00, 16'h0100, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0080, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    // R4 carry tests (second one also R10)
    '{8'd4, 8'h40, 8'h05, 8'h00, 16'h2000, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 16'h2005, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{8'd10, 8'h40, 8'h05, 8'h00, 16'h2000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 16'h2000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{8'd4, 8'h50, 8'hF0, 8'h00, 16'h2000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 16'h1FF0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    // R5 accumulator zero tests
    '{8'd5, 8'h60, 8'h02, 8'h00, 16'h3000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 16'h3002, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{8'd5, 8'h60, 8'h02, 8'h00, 16'h3000, 8'h80, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 16'h3000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{8'd5, 8'h70, 8'h7F, 8'h00, 16'h3000, 8'h01, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 16'h307F, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    // R6 indirect
    '{8'd6, 8'h73, 8'h00, 8'h00, 16'h0000, 8'hFF, 16'h1234, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 16'h1333, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{8'd6, 8'h73, 8'h00, 8'h00, 16'h0000, 8'h20, 16'hFFF0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    // R7 compare
    '{8'd7, 8'hB4, 8'h00, 8'h08, 16'h4000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h10, 8'h20, 8'h00, 16'h4008, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
    '{8'd7, 8'hB5, 8'h00, 8'hF8, 16'h4000, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h20, 8'h10, 8'h00, 16'h3FF8, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    '{8'd7, 8'hBF, 8'h00, 8'h08, 16'h4000, 8'h00, 16'h0000, 1'b1, 1'b0, 8'h55, 8'h55, 8'h00, 16'h4000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    '{8'd7, 8'hB6, 8'h00, 8'h01, 16'h4000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'hFF, 8'h00, 16'h4001, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
    // R8 decrement
    '{8'd8, 8'hD5, 8'h99, 8'hFC, 16'h5000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h02, 16'h4FFC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01},
    '{8'd8, 8'hD8, 8'h10, 8'h00, 16'h5000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 16'h5000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00},
    '{8'd8, 8'hDF, 8'h10, 8'h00, 16'h5000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 16'h5010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF},
    // R9 bit tests
    '{8'd9, 8'h20, 8'h77, 8'h04, 16'h6000, 8'h00, 16'h0000, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 16'h6004, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{8'd9, 8'h30, 8'h77, 8'h04, 16'h6000, 8'h00, 16'h0000, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 16'h6000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{8'd9, 8'h30, 8'h77, 8'h04, 16'h6000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 16'h6004, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{8'd9, 8'h10, 8'h77, 8'h04, 16'h6000, 8'h00, 16'h0000, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 16'h6004, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
    '{8'd9, 8'h10, 8'h77, 8'h04, 16'h6000, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 16'h6000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    // R11 unrecognised opcodes
    '{8'd11, 8'hA5, 8'h55, 8'h66, 16'h7000, 8'h00, 16'h1111, 1'b1, 1'b1, 8'h01, 8'h02, 8'h05, 16'h7000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{8'd11, 8'h12, 8'h55, 8'h66, 16'h7000, 8'h00, 16'h1111, 1'b1, 1'b1, 8'h01, 8'h02, 8'h05, 16'h7000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{8'd11, 8'h03, 8'h55, 8'h66, 16'h7000, 8'h00, 16'h1111, 1'b1, 1'b1, 8'h01, 8'h02, 8'h05, 16'h7000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}
  };

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    op = v.op; opnd1 = v.o1; opnd2 = v.o2; pc_seq = v.pc; acc = v.acc;
    dptr = v.dp; cy_in = v.cy; bit_val = v.bt; cmp_lhs = v.lhs;
    cmp_rhs = v.rhs; dec_src = v.dsrc;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R12 watchdog expired: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] held_pc;
    rst_n = 1'b0; in_valid = 1'b0;
    drive(TBL[0]);
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(out_valid == 1'b0, 12, "reset out_valid", 32'(out_valid), 0);
    chk({taken, cy_we, bit_clr, dec_we} == 4'b0, 12, "reset strobes",
        32'({taken, cy_we, bit_clr, dec_we}), 0);
    chk(next_pc == 16'h0, 12, "reset next_pc", 32'(next_pc), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b1, 12, "out_valid", 32'(out_valid), 1);
      chk(next_pc == TBL[i].e_pc, TBL[i].req, "next_pc", 32'(next_pc), 32'(TBL[i].e_pc));
      chk(taken == TBL[i].e_tk, TBL[i].req, "taken", 32'(taken), 32'(TBL[i].e_tk));
      chk(cy_we == TBL[i].e_cwe, TBL[i].req, "cy_we", 32'(cy_we), 32'(TBL[i].e_cwe));
      if (TBL[i].e_cwe)
        chk(cy_new == TBL[i].e_cy, TBL[i].req, "cy_new", 32'(cy_new), 32'(TBL[i].e_cy));
      chk(bit_clr == TBL[i].e_bclr, TBL[i].req, "bit_clr", 32'(bit_clr), 32'(TBL[i].e_bclr));
      chk(dec_we == TBL[i].e_dwe, TBL[i].req, "dec_we", 32'(dec_we), 32'(TBL[i].e_dwe));
      if (TBL[i].e_dwe)
        chk(dec_val == TBL[i].e_dval, TBL[i].req, "dec_val", 32'(dec_val), 32'(TBL[i].e_dval));
    end

    // R12 idle cycle: strobes drop, next_pc holds even with new inputs
    drive(TBL[24]);
    in_valid = 1'b1;
    @(negedge clk);
    held_pc = next_pc;
    chk(bit_clr == 1'b1, 9, "bit_clr before idle", 32'(bit_clr), 1);
    in_valid = 1'b0;
    drive(TBL[0]);
    @(negedge clk);
    chk(out_valid == 1'b0, 12, "idle out_valid", 32'(out_valid), 0);
    chk({taken, cy_we, bit_clr, dec_we} == 4'b0, 12, "idle strobes",
        32'({taken, cy_we, bit_clr, dec_we}), 0);
    chk(next_pc == held_pc, 12, "idle next_pc hold", 32'(next_pc), 32'(held_pc));

    // R12 asynchronous reset in the middle of a result
    drive(TBL[19]);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(dec_we == 1'b1, 8, "dec_we before reset", 32'(dec_we), 1);
    rst_n = 1'b0;
    #1;
    chk({out_valid, dec_we, taken} == 3'b0, 12, "async reset clears",
        32'({out_valid, dec_we, taken}), 0);
    chk(dec_val == 8'h00, 12, "async reset dec_val", 32'(dec_val), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 again after reset: unit works once released
    drive(TBL[4]);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(next_pc == 16'hFFFF, 3, "post-reset wrap", 32'(next_pc), 32'hFFFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule